// File: doc/BRIEF.md
# Microcoded Rising-Edge Detector

This block is a very small microprogrammed controller whose fixed eight-word program turns it into a Moore-style detector of rising edges on a single level input. A three-bit microprogram counter addresses an eight-bit-wide ROM. Each word is one of two kinds. An output word loads a registered output bit. A test word either jumps to a target address or falls through to the next address, depending on the input level. Because each word can choose between only two successors, the detector's decisions are laid out as a chain of single test words.

The controller clock is assumed to run at twice the rate at which the level input may change, and the input is synchronous to that clock. For every rise of the input that the program sees, the output goes high for exactly one controller cycle. Because the output is a register, it follows the output word that drives it by one cycle.

Top module: `edge_ucode_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the output to 0 and restarts execution at address 0. The output reads 0 in the cycle after a reset edge.
- R2: A word with bit 7 equal to 0 is an output word. At the next edge the output takes the value of bit 0, and the counter advances by one.
- R3: A word with bit 7 equal to 1 and bit 6 equal to 1 is a test word. When the input is 1, it loads the counter from bits 2..0.
- R4: A word with bit 7 equal to 1 and bit 6 equal to 0 is a test word. When the input is 0, it loads the counter from bits 2..0.
- R5: A test word whose condition is false advances the counter by one, and address 7 wraps to address 0. No test word changes the output.
- R6: The output keeps its value in every cycle that does not execute an output word.
- R7: The ROM holds, for addresses 0 through 7: 0x00, 0xC0, 0x00, 0x82, 0x01, 0x00, 0xC1, 0x81. The output is therefore never high for two consecutive cycles.
- R8: Suppose the input holds each level for at least four controller cycles. Then each rise of the input produces exactly one output pulse, and a steady input produces none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| level_i | input | 1 | Level being watched, synchronous to clk |
| pulse_o | output | 1 | Registered detector output, high for one cycle per detected rise |

## Verification
The assertions assume that `level_i` changes only between clock edges and that reset is held across at least one edge before any property is evaluated. They also assume the ROM contents listed in R7, which the pulse-width property depends on. The stimulus changes the input one time unit after an edge and holds each value for at least two cycles, which matches the half-rate input. The exhaustive sweep runs every eight-step input pattern back to back against a word-by-word interpretation of the listed program. The four-cycle minimum hold of R8 applies only to the pulse-count sweep.

// File: rtl/edge_ucode_pkg.sv
`timescale 1ns/1ps
// Package: edge_ucode_pkg
// Shared widths, field positions and the fixed microprogram of the
// edge detector controller. Assumes an 8-bit word and a 3-bit address.
package edge_ucode_pkg;

    localparam int UADDR_W  = 3;
    localparam int UWORD_W  = 8;
    localparam int KIND_BIT = 7;   // 0: output word, 1: test word
    localparam int POL_BIT  = 6;   // test word: level that makes the jump taken
    localparam int VAL_BIT  = 0;   // output word: new output value

    typedef logic [UWORD_W-1:0] uword_t;

    // Fixed program: hold-high wait, hold-low wait, one-word pulse, return.
    function automatic uword_t prog_word(input int idx);
        uword_t w;
        case (idx)
            0:       w = 8'h00;   // output 0
            1:       w = 8'hC0;   // level 1 -> 0 (wait for low)
            2:       w = 8'h00;   // output 0
            3:       w = 8'h82;   // level 0 -> 2 (wait for high)
            4:       w = 8'h01;   // output 1 (pulse)
            5:       w = 8'h00;   // output 0
            6:       w = 8'hC1;   // level 1 -> 1
            7:       w = 8'h81;   // level 0 -> 1
            default: w = 8'h00;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ucode_rom.sv
`timescale 1ns/1ps
// Module: ucode_rom
// Read-only microprogram store with an asynchronous read port.
// Assumes the contents come from edge_ucode_pkg::prog_word.
module ucode_rom #(
    parameter int ADDR_W = 3,
    parameter int WORD_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // One constant word per address, filled from the package program.
    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
        assign mem[g] = WORD_W'(edge_ucode_pkg::prog_word(g));
    end

    // Combinational read of the addressed word.
    assign word = mem[addr];

endmodule

// File: rtl/ucode_seq.sv
`timescale 1ns/1ps
// Module: ucode_seq
// Microprogram counter and next-address logic. An output word and an
// untaken test word step by one; a taken test word loads its target.
// Assumes level_i is synchronous to clk.
module ucode_seq #(
    parameter int ADDR_W   = 3,
    parameter int WORD_W   = 8,
    parameter int KIND_BIT = 7,
    parameter int POL_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              level_i,
    output logic [ADDR_W-1:0] pc,
    output logic              is_out_word
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic              is_test;
    logic              taken;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] pc_nxt;

    // Decode the word kind and the two-way branch decision.
    always_comb begin
        is_test     = word[KIND_BIT];
        is_out_word = ~word[KIND_BIT];
        target      = word[ADDR_W-1:0];
        taken       = is_test && (word[POL_BIT] == level_i);
        pc_nxt      = taken ? target : pc + STEP;
    end

    // Counter register with synchronous reset to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_nxt;
    end

    assert_reset_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc == '0);

    assert_jump_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word[KIND_BIT]) && $past(word[POL_BIT]) && $past(level_i))
        |-> pc == $past(word[ADDR_W-1:0]));

    assert_jump_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word[KIND_BIT]) && !$past(word[POL_BIT]) && !$past(level_i))
        |-> pc == $past(word[ADDR_W-1:0]));

    assert_fallthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word[KIND_BIT]) && ($past(word[POL_BIT]) != $past(level_i)))
        |-> pc == $past(pc) + STEP);

    assert_out_word_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(word[KIND_BIT])) |-> pc == $past(pc) + STEP);

endmodule

// File: rtl/ucode_out_reg.sv
`timescale 1ns/1ps
// Module: ucode_out_reg
// Registered output bit, loaded only by output words and held otherwise.
// Assumes load and val are settled before each clock edge.
module ucode_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic val,
    output logic q
);
    // Output register: clear on reset, load on an output word, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= val;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !q);

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load)) |-> q == $past(val));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> $stable(q));

endmodule

// File: rtl/edge_ucode_ctrl.sv
`timescale 1ns/1ps
// Module: edge_ucode_ctrl
// Top of the microcoded rising-edge detector: ROM, sequencer and output
// register. Assumes level_i changes at most every other clock cycle and
// is synchronous to clk. Reset is synchronous and active low.
module edge_ucode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    import edge_ucode_pkg::*;

    localparam int AW = UADDR_W;
    localparam int WW = UWORD_W;

    logic [AW-1:0] pc;
    logic [WW-1:0] word;
    logic          is_out_word;

    // Microprogram store addressed by the counter.
    ucode_rom #(.ADDR_W(AW), .WORD_W(WW)) u_rom (
        .addr (pc),
        .word (word)
    );

    // Counter and two-way branch unit.
    ucode_seq #(.ADDR_W(AW), .WORD_W(WW), .KIND_BIT(KIND_BIT), .POL_BIT(POL_BIT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .word        (word),
        .level_i     (level_i),
        .pc          (pc),
        .is_out_word (is_out_word)
    );

    // Registered output bit.
    ucode_out_reg u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (is_out_word),
        .val   (word[VAL_BIT]),
        .q     (pulse_o)
    );

    assert_single_cycle_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pulse_o)) |-> !pulse_o);

    assert_pulse_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(pulse_o)) |-> pc == AW'(5));

endmodule

// File: tb/edge_ucode_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: interprets the listed program word by word and compares pulse_o
// every cycle; also counts pulses against input rises for slow patterns.
module edge_ucode_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic level_i = 1'b0;
    logic pulse_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] m_pc = 3'd0;
    logic       m_out = 1'b0;
    logic       prev_lvl = 1'b0;
    logic       prev_out = 1'b0;
    int         lvl_rises = 0;
    int         out_rises = 0;

    always #2.5 clk = ~clk;

    edge_ucode_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_i),
        .pulse_o (pulse_o)
    );

    // Program as written in R7.
    function automatic logic [7:0] ref_word(input logic [2:0] a);
        case (a)
            3'd0: return 8'h00;
            3'd1: return 8'hC0;
            3'd2: return 8'h00;
            3'd3: return 8'h82;
            3'd4: return 8'h01;
            3'd5: return 8'h00;
            3'd6: return 8'hC1;
            default: return 8'h81;
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pc_model=%0d actual=%0b expected=%0b", tag, m_pc, act, exp);
        end
    endtask

    // One controller cycle: drive the level, interpret one word, compare.
    task automatic step(input logic v);
        logic [7:0] w;
        string tag;
        w = ref_word(m_pc);
        if (!w[7]) begin
            m_out = w[0];
            m_pc  = m_pc + 3'd1;
            tag   = "R2";
        end else if (w[6] == v) begin
            m_pc = w[2:0];
            tag  = w[6] ? "R3" : "R4";
        end else begin
            m_pc = m_pc + 3'd1;
            tag  = "R5/R6";
        end
        if (v && !prev_lvl) lvl_rises++;
        prev_lvl = v;
        level_i = v;
        @(posedge clk);
        #1;
        check(pulse_o, m_out, tag);
        if (prev_out) check(pulse_o, 1'b0, "R7 width");
        if (pulse_o && !prev_out) out_rises++;
        prev_out = pulse_o;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        level_i = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(pulse_o, 1'b0, "R1 reset");
        rst_n = 1'b1;
        m_pc = 3'd0;
        m_out = 1'b0;
        prev_lvl = 1'b0;
        prev_out = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int hold;
        logic lv;
        do_reset();

        // R7: exhaustive sweep of every 8-step pattern, 2 cycles per step.
        for (int pat = 0; pat < 256; pat++) begin
            for (int b = 0; b < 8; b++) begin
                step(pat[b]);
                step(pat[b]);
            end
        end

        // R1: reset while the output is high clears it.
        for (int k = 0; k < 40 && !m_out; k++) step(k[1]);
        check(pulse_o, m_out, "R1 pre-reset");
        do_reset();
        step(1'b1);
        step(1'b1);

        // R8: slow patterns, holds of 4..9 cycles, pulses must equal rises.
        do_reset();
        for (int k = 0; k < 12; k++) step(1'b0);
        lvl_rises = 0;
        out_rises = 0;
        seed = 7;
        lv = 1'b0;
        for (int seg = 0; seg < 400; seg++) begin
            seed = (seed * 37 + 11) % 101;
            hold = 4 + (seed % 6);
            lv = ~lv;
            for (int c = 0; c < hold; c++) step(lv);
        end
        for (int k = 0; k < 12; k++) step(1'b0);
        checks++;
        if (out_rises != lvl_rises) begin
            errors++;
            $display("FAIL R8 pulses actual=%0d expected=%0d", out_rises, lvl_rises);
        end

        // R8: long steady high and low produce no pulses.
        out_rises = 0;
        for (int k = 0; k < 30; k++) step(1'b1);
        out_rises = 0;
        for (int k = 0; k < 30; k++) step(1'b1);
        for (int k = 0; k < 30; k++) step(1'b0);
        checks++;
        if (out_rises != 0) begin
            errors++;
            $display("FAIL R8 steady actual=%0d expected=0", out_rises);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule